// File: doc/BRIEF.md
# Row-Addressed Scan Test Controller

This block sequences test vectors through an array of scan cells that is organised as rows rather than as a serial chain. There is no column decoder. A single row-select register holds one active bit. When a row is selected, every cell in that row is reached at once over a bus that is as wide as the number of columns served per access. For each vector the controller visits the rows in ascending order. For each row it first reads the current contents and folds them into a signature register, and only then writes the new stimulus word.

Once every row of a vector has been written, the controller drops test mode for a single cycle and raises a capture enable. The logic under test then clocks its response into the cells, and the next vector reads that response. After the last vector the signature register is shifted out serially, most significant bit first, and a done flag rises and stays high until the next start.

The cell array and the logic under test sit outside the block. The controller only drives the row selects, the write strobe, the test-mode level and the capture enable. It samples the row read bus and passes the stimulus word through to the array unchanged.

Top module: `rascan_ctrl`

## Requirements
- R1: While rst_n is low at a rising edge, the block returns to idle from any state. In idle, tmode, wr_stb, cap_en, sig_valid, sig_out and done are 0 and row_en is all zero.
- R2: A go pulse sampled in idle or after done starts a run. In the next cycle tmode is 1 and row_en selects row 0 (row_en == 1).
- R3: During the access cycles row_en has exactly one bit set, and bit k selects row k. The rows are visited in the order 0, 1, ..., ROWS-1 for every vector. In every other cycle row_en is all zero.
- R4: Each row takes two cycles. The read cycle has wr_stb at 0. The write cycle follows it with the same row_en and wr_stb at 1, and the array stores stim_data at the end of the write cycle.
- R5: The signature register is cleared at the start of a run. At the end of each read cycle it becomes {s[W-2:0],0} XOR (s[W-1] ? POLY : 0) XOR rd_data, where POLY defaults to 8'h1D.
- R6: After the write cycle of the last row there is exactly one cycle with cap_en = 1, tmode = 0 and row_en = 0. The next vector then starts again at row 0.
- R7: After NVEC vectors, sig_valid is 1 for COLS cycles. During these cycles tmode is 1 and sig_out carries the signature from bit COLS-1 down to bit 0.
- R8: done is 1 from the cycle after the last signature bit and stays 1 until a new go is sampled.
- R9: A go sampled while a run is in progress has no effect on the sequence or on the signature.
- R10: A second run on the same array contents and the same stimulus gives the same signature, because no signature state carries over between runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start request, taken only when idle or done |
| stim_data | input | COLS | New stimulus word for the selected row |
| rd_data | input | COLS | Current contents of the selected row |
| tmode | output | 1 | Test-mode level for the array |
| row_en | output | ROWS | One-hot row select |
| wr_stb | output | 1 | Row write strobe |
| cap_en | output | 1 | Functional capture clock enable |
| sig_out | output | 1 | Serial signature bit |
| sig_valid | output | 1 | Marks signature shift cycles |
| done | output | 1 | Run finished |

## Verification
A start request can arrive in the same cycle as another piece of work. It can coincide with a row read that is folding data into the signature, or with the cycle that shifts out the last signature bit. The bench provokes both: it holds go high during the read of row 1 in one run, and during the final shift cycle in another. It then judges the result against a per-cycle expectation of row selects, strobes and capture pulses, and against a signature computed by its own model of the array and the compaction. A stray restart would show up as a broken row order, as a signature that does not match, or as done arriving late.

// File: rtl/rsc_pkg.sv
// Shared types for the row-addressed scan controller.
// Assumes: used by every module of the controller.
package rsc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_WRITE = 3'd2,
        ST_CAPT  = 3'd3,
        ST_SHIFT = 3'd4,
        ST_DONE  = 3'd5
    } rsc_state_e;
endpackage

// File: rtl/rsc_row_ring.sv
// One-hot row pointer. Load puts the pointer on row 0, and adv moves it one row up.
// Assumes: load and adv are never high together; ROWS >= 2.
module rsc_row_ring #(
    parameter int ROWS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            adv,
    output logic [ROWS-1:0] ring,
    output logic            last
);
    // Pointer register: reset and load to row 0, rotate left on advance.
    always_ff @(posedge clk) begin
        if (!rst_n || load)
            ring <= ROWS'(1);
        else if (adv)
            ring <= {ring[ROWS-2:0], ring[ROWS-1]};
    end

    assign last = ring[ROWS-1];

    // R3
    ring_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ring) == 1);

    // R3
    ring_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && !last) |=> !ring[0]);
endmodule

// File: rtl/rsc_misr.sv
// Signature register. It clears, folds in a row word through a multiple-input
// feedback shift, or shifts left to bring the signature out from its top bit.
// Assumes: W >= 2; clr takes priority over fold, and fold over shift.
module rsc_misr #(
    parameter int         W    = 8,
    parameter logic [W-1:0] POLY = 8'h1D
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         fold,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         sig_bit
);
    logic [W-1:0] q;
    logic [W-1:0] fb;

    // Feedback term that is applied when the top bit leaves the register.
    always_comb fb = q[W-1] ? POLY : '0;

    // Signature state update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            q <= '0;
        else if (fold)
            q <= {q[W-2:0], 1'b0} ^ fb ^ din;
        else if (shift)
            q <= {q[W-2:0], 1'b0};
    end

    assign sig_bit = q[W-1];

    // R7
    sig_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !fold && !clr) |=> (sig_bit == $past(q[W-2])));

    // R5
    misr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !fold && !shift) |=> $stable(q));
endmodule

// File: rtl/rsc_seq.sv
// Run sequencer. It walks read/write pairs per row, one capture per vector, then
// COLS shift cycles, and drives the strobes for the ring and the signature register.
// Assumes: NVEC >= 1, COLS >= 2; row_last comes from the row ring.
module rsc_seq
    import rsc_pkg::*;
#(
    parameter int NVEC = 3,
    parameter int COLS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       row_last,
    output rsc_state_e st,
    output logic       ring_load,
    output logic       ring_adv,
    output logic       misr_clr,
    output logic       misr_fold,
    output logic       misr_shift
);
    localparam int VW = (NVEC > 1) ? $clog2(NVEC) : 1;
    localparam int BW = $clog2(COLS);

    logic [VW-1:0] vcnt;
    logic [BW-1:0] bcnt;
    logic          start;

    // Start is accepted only when no run is in progress.
    always_comb start = go && (st == ST_IDLE || st == ST_DONE);

    // Strobes to the ring and the signature register.
    always_comb begin
        ring_load  = start || (st == ST_CAPT);
        ring_adv   = (st == ST_WRITE) && !row_last;
        misr_clr   = start;
        misr_fold  = (st == ST_READ);
        misr_shift = (st == ST_SHIFT);
    end

    // State, vector counter and shift counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            vcnt <= '0;
            bcnt <= '0;
        end else begin
            case (st)
                ST_IDLE, ST_DONE: if (go) begin
                    st   <= ST_READ;
                    vcnt <= '0;
                end
                ST_READ:  st <= ST_WRITE;
                ST_WRITE: st <= row_last ? ST_CAPT : ST_READ;
                ST_CAPT: begin
                    if (vcnt == VW'(NVEC - 1)) begin
                        st   <= ST_SHIFT;
                        bcnt <= '0;
                    end else begin
                        vcnt <= vcnt + 1'b1;
                        st   <= ST_READ;
                    end
                end
                ST_SHIFT: begin
                    bcnt <= bcnt + 1'b1;
                    if (bcnt == BW'(COLS - 1))
                        st <= ST_DONE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE && !go) |=> (st == ST_DONE));

    // R9
    busy_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ && go) |=> (st == ST_WRITE));
endmodule

// File: rtl/rascan_ctrl.sv
// Top of the row-addressed scan controller. It ties the sequencer, the row ring
// and the signature register together and decodes the array-side controls.
// Assumes: the array returns the selected row on rd_data in the same cycle and
// stores stim_data at the end of a cycle that has wr_stb high.
module rascan_ctrl
    import rsc_pkg::*;
#(
    parameter int           ROWS = 4,
    parameter int           COLS = 8,
    parameter int           NVEC = 3,
    parameter logic [COLS-1:0] POLY = 8'h1D
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [COLS-1:0] stim_data,
    input  logic [COLS-1:0] rd_data,
    output logic            tmode,
    output logic [ROWS-1:0] row_en,
    output logic            wr_stb,
    output logic            cap_en,
    output logic            sig_out,
    output logic            sig_valid,
    output logic            done
);
    rsc_state_e      st;
    logic            ring_load, ring_adv, row_last;
    logic            misr_clr, misr_fold, misr_shift, sig_bit;
    logic [ROWS-1:0] ring;
    logic            access;

    rsc_seq #(.NVEC(NVEC), .COLS(COLS)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .row_last(row_last), .st(st),
        .ring_load(ring_load), .ring_adv(ring_adv), .misr_clr(misr_clr),
        .misr_fold(misr_fold), .misr_shift(misr_shift)
    );

    rsc_row_ring #(.ROWS(ROWS)) u_ring (
        .clk(clk), .rst_n(rst_n), .load(ring_load), .adv(ring_adv),
        .ring(ring), .last(row_last)
    );

    rsc_misr #(.W(COLS), .POLY(POLY)) u_misr (
        .clk(clk), .rst_n(rst_n), .clr(misr_clr), .fold(misr_fold),
        .shift(misr_shift), .din(rd_data), .sig_bit(sig_bit)
    );

    // Array-side decode from the sequencer state.
    always_comb begin
        access    = (st == ST_READ) || (st == ST_WRITE);
        row_en    = access ? ring : '0;
        tmode     = access || (st == ST_SHIFT);
        wr_stb    = (st == ST_WRITE);
        cap_en    = (st == ST_CAPT);
        sig_valid = (st == ST_SHIFT);
        sig_out   = sig_valid && sig_bit;
        done      = (st == ST_DONE);
    end

    // The stimulus word goes straight to the array; it is not used here.
    logic unused_stim;
    always_comb unused_stim = ^stim_data;

    // R6
    cap_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> (!tmode && row_en == '0 && !wr_stb));

    // R4
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (!$past(wr_stb) && row_en == $past(row_en)));
endmodule

// File: tb/sim_rascan_ctrl.sv
// Bench: models the cell array and the logic under test, walks a table of runs,
// then exercises reset and restart corner cases.
module sim_rascan_ctrl;
    localparam int ROWS = 4;
    localparam int W    = 8;
    localparam int NVEC = 3;
    localparam logic [W-1:0] POLY = 8'h1D;
    localparam int NRUN = 4;
    localparam int RUN_SEED [NRUN] = '{1, 2, 3, 1};
    localparam bit RUN_MID  [NRUN] = '{1'b0, 1'b1, 1'b0, 1'b0};
    localparam bit RUN_END  [NRUN] = '{1'b0, 1'b0, 1'b1, 1'b0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0;
    logic [W-1:0] stim_data = '0;
    logic [W-1:0] rd_data;
    logic tmode, wr_stb, cap_en, sig_out, sig_valid, done;
    logic [ROWS-1:0] row_en;

    logic init_load = 1'b0;
    int   init_seed = 0;
    logic [W-1:0] cells [ROWS];

    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    rascan_ctrl #(.ROWS(ROWS), .COLS(W), .NVEC(NVEC), .POLY(POLY)) u0 (
        .clk(clk), .rst_n(rst_n), .go(go), .stim_data(stim_data), .rd_data(rd_data),
        .tmode(tmode), .row_en(row_en), .wr_stb(wr_stb), .cap_en(cap_en),
        .sig_out(sig_out), .sig_valid(sig_valid), .done(done)
    );

    function automatic logic [W-1:0] init_fn(int s, int r);
        return W'(s * 53 + r * 29 + 7);
    endfunction

    function automatic logic [W-1:0] stim_fn(int s, int v, int r);
        return W'(s * 101 + v * 17 + r * 45 + 3);
    endfunction

    function automatic logic [W-1:0] func_row(logic [W-1:0] a, logic [W-1:0] b, int r);
        return a ^ {b[W-2:0], b[W-1]} ^ W'(r + 1);
    endfunction

    function automatic logic [W-1:0] misr_step(logic [W-1:0] m, logic [W-1:0] d);
        return {m[W-2:0], 1'b0} ^ (m[W-1] ? POLY : '0) ^ d;
    endfunction

    // Reference: expected signature for one run (R5, R6).
    function automatic logic [W-1:0] ref_sig(int s);
        logic [W-1:0] c [ROWS];
        logic [W-1:0] n [ROWS];
        logic [W-1:0] m;
        m = '0;
        for (int r = 0; r < ROWS; r++) c[r] = init_fn(s, r);
        for (int v = 0; v < NVEC; v++) begin
            for (int r = 0; r < ROWS; r++) begin
                m    = misr_step(m, c[r]);
                c[r] = stim_fn(s, v, r);
            end
            for (int r = 0; r < ROWS; r++) n[r] = func_row(c[r], c[(r + 1) % ROWS], r);
            for (int r = 0; r < ROWS; r++) c[r] = n[r];
        end
        return m;
    endfunction

    // Array and logic-under-test model.
    always_ff @(posedge clk) begin
        if (init_load) begin
            for (int r = 0; r < ROWS; r++) cells[r] <= init_fn(init_seed, r);
        end else if (wr_stb) begin
            for (int r = 0; r < ROWS; r++) if (row_en[r]) cells[r] <= stim_data;
        end else if (cap_en) begin
            for (int r = 0; r < ROWS; r++) cells[r] <= func_row(cells[r], cells[(r + 1) % ROWS], r);
        end
    end

    // Row read bus from the selected row.
    always_comb begin
        rd_data = '0;
        for (int r = 0; r < ROWS; r++) if (row_en[r]) rd_data = rd_data | cells[r];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_one(input int seed, input bit mid_go, input bit end_go,
                           output logic [W-1:0] got);
        int e3 = 0, e4 = 0, e6 = 0, e7 = 0;
        logic [W-1:0] exp_sig;
        exp_sig = ref_sig(seed);
        got = '0;
        init_seed = seed;
        init_load = 1'b1;
        @(negedge clk);
        init_load = 1'b0;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk(tmode && row_en == ROWS'(1), "R2 first read on row 0", int'(row_en), 1);
        for (int v = 0; v < NVEC; v++) begin
            for (int r = 0; r < ROWS; r++) begin
                if (row_en != ROWS'(1 << r) || wr_stb || !tmode || cap_en) e3++;
                if (mid_go && v == 0 && r == 1) go = 1'b1;
                @(negedge clk);
                go = 1'b0;
                stim_data = stim_fn(seed, v, r);
                if (row_en != ROWS'(1 << r) || !wr_stb || !tmode) e4++;
                @(negedge clk);
            end
            if (!cap_en || tmode || row_en != '0 || wr_stb) e6++;
            @(negedge clk);
        end
        for (int b = 0; b < W; b++) begin
            if (!sig_valid || !tmode || done) e7++;
            got = {got[W-2:0], sig_out};
            if (end_go && b == W - 1) go = 1'b1;
            @(negedge clk);
            go = 1'b0;
        end
        chk(e3 == 0, "R3 row order / read cycles", e3, 0);
        chk(e4 == 0, "R4 write follows read", e4, 0);
        chk(e6 == 0, "R6 capture cycle", e6, 0);
        chk(e7 == 0, "R7 shift window", e7, 0);
        chk(got == exp_sig, "R5 R7 signature", int'(got), int'(exp_sig));
        if (mid_go || end_go)
            chk(got == exp_sig, "R9 go while busy", int'(got), int'(exp_sig));
        chk(done && !sig_valid, "R8 done after last bit", int'(done), 1);
        repeat (3) @(negedge clk);
        chk(done && !tmode && row_en == '0, "R8 done held", int'(done), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] first_sig, sig;
        first_sig = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!tmode, "R1 tmode idle", int'(tmode), 0);
        chk(row_en == '0, "R1 row_en idle", int'(row_en), 0);
        chk(!wr_stb && !cap_en, "R1 strobes idle", int'({wr_stb, cap_en}), 0);
        chk(!sig_valid && !sig_out && !done, "R1 shift/done idle",
            int'({sig_valid, sig_out, done}), 0);

        for (int i = 0; i < NRUN; i++) begin
            if (i == NRUN - 1) begin
                // R1: synchronous reset in the middle of a run
                go = 1'b1;
                @(negedge clk);
                go = 1'b0;
                repeat (5) @(negedge clk);
                rst_n = 1'b0;
                @(negedge clk);
                chk(!tmode && row_en == '0 && !wr_stb && !cap_en && !done,
                    "R1 mid-run reset", int'({tmode, row_en}), 0);
                rst_n = 1'b1;
                @(negedge clk);
            end
            run_one(RUN_SEED[i], RUN_MID[i], RUN_END[i], sig);
            if (i == 0) first_sig = sig;
        end
        // R10: repeated run from the same contents gives the same signature
        chk(sig == first_sig, "R10 repeat signature", int'(sig), int'(first_sig));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule